// File: doc/BRIEF.md
# Sub-audio Host Serial Register Port

This block is the host-facing side of a sub-audio signalling core. A microcontroller drives a serial clock, a command data line and an active-low chip select. The block returns reply data on a line whose driver is switched off whenever no reply is in flight. The host SCLK, data and select lines are resampled with the fast system clock, so the whole block runs in one clock domain. Serial clock edges are found by comparing successive synchronised samples.

Each transaction opens with a command byte. Depending on the code, zero, one or two write bytes follow, or one status byte is shifted back to the host. The block holds the control words for the core: a sub-audio control byte, an audio control byte, a 16-bit transmit tone word and a tone-cloning enable. It raises one-cycle strobes for three events: a receive-slot programming write (3-bit slot number and 12-bit frequency word), a completed status read (which the core uses to clear its interrupt) and a general reset command.

A command only takes effect when the chip select rises after all of its bytes. An early rise abandons the transaction with no side effect.

Top module: `subtone_host_port`

## Requirements
- R1: Serial bits are taken on rising serial clock edges, most significant bit first, and the first byte after chip select falls is the command code.
- R2: Command 0x80 with one data byte loads the sub-audio control output. Command 0x82 with one data byte loads the audio control output.
- R3: Command 0x83 takes two data bytes. The first byte lands in bits 15:8 of the transmit tone word and the second in bits 7:0.
- R4: Command 0x84 takes two data bytes and produces a single-cycle slot write strobe. Its slot number is bits 6:4 of the first byte, and its frequency word is bits 3:0 of the first byte followed by all of the second byte.
- R5: Command 0x9C takes one data byte, and its bit 0 sets the tone-cloning enable: 0x01 turns it on, 0x00 turns it off.
- R6: Command 0x01 carries no data. It zeroes both control bytes, the transmit tone word and the cloning enable, and pulses the general reset strobe for one cycle. The tone decode status bits are not touched, so a later status read still returns the status input.
- R7: Command 0x81 returns one reply byte equal to four zero bits followed by the 4-bit status input, MSB first. Each bit is valid at the rising serial clock edge on which the host samples it.
- R8: A status read whose eight reply bits all completed before chip select rises pulses the status-read strobe once. A status read cut short pulses nothing.
- R9: The reply output enable is high only while reply bits are being sent, and is low again after chip select rises.
- R10: A command acts only when chip select rises. If chip select rises before the required bytes are complete, or in the middle of a byte, no register changes and no strobe fires.
- R11: A command code outside the set above is ignored along with its data: no register changes, no strobe and no reply drive.
- R12: Whole bytes beyond the number a write needs are discarded, and the write still takes effect with its first data bytes.
- R13: After hardware reset all register outputs and strobes are zero and the reply enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, more than four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Host command data |
| csn_i | input | 1 | Active-low chip select |
| sdo_d_o | output | 1 | Reply data bit |
| sdo_oe_o | output | 1 | Reply driver enable; pad floats when low |
| stat_i | input | STAT_W | Tone decode flag and tone number from the core |
| sub_ctl_o | output | 8 | Sub-audio control byte |
| aud_ctl_o | output | 8 | Audio control byte |
| tx_word_o | output | 16 | Transmit tone word |
| clone_en_o | output | 1 | Tone-cloning enable |
| slot_wr_o | output | 1 | One-cycle receive slot programming strobe |
| slot_addr_o | output | 3 | Slot number for the strobe |
| slot_freq_o | output | 12 | Frequency word for the strobe |
| stat_rd_o | output | 1 | One-cycle strobe after a completed status read |
| gen_rst_o | output | 1 | One-cycle strobe after a general reset command |

## Verification
The bench cuts transactions short in two ways: after the command byte, and five bits into a data byte. A design that commits on byte count alone, or acts before select rises, would change a register there. A status read is abandoned halfway through its reply, which catches a design that clears the interrupt on command decode rather than on a full reply. Trailing surplus bytes, an unknown code carrying data, and reply bits checked at the host's exact sample edges expose, respectively, a shifted data capture, a stray strobe or reply drive, and a reply that is one bit late or reversed.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int BYTE_W  = 8;
  localparam int SLOT_AW = 3;
  localparam int FREQ_W  = 12;
  localparam int WORD_W  = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] CMD_RST    = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_SUBCTL = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_STAT   = 8'h81;
  localparam logic [BYTE_W-1:0] CMD_AUDCTL = 8'h82;
  localparam logic [BYTE_W-1:0] CMD_TXW    = 8'h83;
  localparam logic [BYTE_W-1:0] CMD_SLOT   = 8'h84;
  localparam logic [BYTE_W-1:0] CMD_CLONE  = 8'h9C;

  // Bytes that follow the command byte (a reply byte counts as one).
  function automatic logic [1:0] cmd_len(input logic [BYTE_W-1:0] c);
    case (c)
      CMD_RST:                                       cmd_len = 2'd0;
      CMD_SUBCTL, CMD_AUDCTL, CMD_CLONE, CMD_STAT:   cmd_len = 2'd1;
      CMD_TXW, CMD_SLOT:                             cmd_len = 2'd2;
      default:                                       cmd_len = 2'd0;
    endcase
  endfunction

  function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
    case (c)
      CMD_RST, CMD_SUBCTL, CMD_STAT, CMD_AUDCTL,
      CMD_TXW, CMD_SLOT, CMD_CLONE: cmd_known = 1'b1;
      default:                      cmd_known = 1'b0;
    endcase
  endfunction

  function automatic logic [SLOT_AW-1:0] slot_of(input logic [BYTE_W-1:0] b1);
    slot_of = b1[BYTE_W-2 -: SLOT_AW];
  endfunction

  function automatic logic [FREQ_W-1:0] freq_of(input logic [BYTE_W-1:0] b1,
                                               input logic [BYTE_W-1:0] b2);
    freq_of = {b1[FREQ_W-BYTE_W-1:0], b2};
  endfunction
endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
  parameter int STAGES = 2   // must be 2 or more
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic csn_i,
  output logic sclk_rise_o,
  output logic sdi_o,
  output logic csn_o,
  output logic cs_rise_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_p, sdi_p, csn_p;
  logic              sclk_d, csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      sdi_p  <= '0;
      csn_p  <= '1;
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
      sdi_p  <= {sdi_p[STAGES-2:0], sdi_i};
      csn_p  <= {csn_p[STAGES-2:0], csn_i};
      sclk_d <= sclk_p[TOP];
      csn_d  <= csn_p[TOP];
    end
  end

  assign sclk_rise_o = sclk_p[TOP] & ~sclk_d;
  assign sdi_o       = sdi_p[TOP];
  assign csn_o       = csn_p[TOP];
  assign cs_rise_o   = csn_p[TOP] & ~csn_d;

  AST_CS_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_o |=> csn_d); // R10
endmodule

// File: rtl/shp_deser.sv
module shp_deser
  import shp_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  input  logic              cs_rise_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              commit_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] d0_o,
  output logic [BYTE_W-1:0] d1_o,
  output logic              sdo_d_o,
  output logic              sdo_oe_o
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam int REP_CW = $clog2(BYTE_W + 1);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, cmd_q, d0_q, d1_q, rep_q;
  logic [BIT_CW-1:0] bit_cnt;
  logic [1:0]        byte_cnt;
  logic [REP_CW-1:0] rep_left;
  logic              oe_q;

  logic [BYTE_W-1:0] byte_w;
  logic              byte_done;
  logic              whole;

  assign byte_w    = {sh_q[BYTE_W-2:0], sdi_i};
  assign byte_done = sclk_rise_i & ~csn_i & (bit_cnt == LAST_BIT);
  assign whole     = (bit_cnt == '0) &&
                     ({1'b0, byte_cnt} >= ({1'b0, cmd_len(cmd_q)} + 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cmd_q    <= '0;
      d0_q     <= '0;
      d1_q     <= '0;
      rep_q    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rep_left <= '0;
      oe_q     <= 1'b0;
    end else if (csn_i) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rep_left <= '0;
      oe_q     <= 1'b0;
    end else if (sclk_rise_i) begin
      sh_q    <= byte_w;
      bit_cnt <= bit_cnt + 1'b1;
      if (oe_q) begin
        rep_q    <= {rep_q[BYTE_W-2:0], 1'b0};
        rep_left <= rep_left - 1'b1;
        if (rep_left == REP_CW'(1)) oe_q <= 1'b0;
      end
      if (byte_done) begin
        case (byte_cnt)
          2'd0:    cmd_q <= byte_w;
          2'd1:    d0_q  <= byte_w;
          2'd2:    d1_q  <= byte_w;
          default: ;
        endcase
        if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
        if (byte_cnt == 2'd0 && byte_w == CMD_STAT) begin
          rep_q    <= {{(BYTE_W-STAT_W){1'b0}}, stat_i};
          rep_left <= REP_CW'(BYTE_W);
          oe_q     <= 1'b1;
        end
      end
    end
  end

  assign commit_o = cs_rise_i & whole & cmd_known(cmd_q);
  assign cmd_o    = cmd_q;
  assign d0_o     = d0_q;
  assign d1_o     = d1_q;
  assign sdo_d_o  = rep_q[BYTE_W-1];
  assign sdo_oe_o = oe_q;

  AST_OE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> !$past(csn_i)); // R9
  AST_OE_DROPS_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_i) |=> !sdo_oe_o); // R9
  AST_REPLY_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rep_left <= REP_CW'(BYTE_W)); // R7
  AST_OE_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> (cmd_q == CMD_STAT)); // R11
  AST_COMMIT_ENDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (byte_cnt == 2'd0 && !sdo_oe_o)); // R10
endmodule

// File: rtl/shp_regfile.sv
module shp_regfile
  import shp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [BYTE_W-1:0]  cmd_i,
  input  logic [BYTE_W-1:0]  d0_i,
  input  logic [BYTE_W-1:0]  d1_i,
  output logic [BYTE_W-1:0]  sub_ctl_o,
  output logic [BYTE_W-1:0]  aud_ctl_o,
  output logic [WORD_W-1:0]  tx_word_o,
  output logic               clone_en_o,
  output logic               slot_wr_o,
  output logic [SLOT_AW-1:0] slot_addr_o,
  output logic [FREQ_W-1:0]  slot_freq_o,
  output logic               stat_rd_o,
  output logic               gen_rst_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_ctl_o   <= '0;
      aud_ctl_o   <= '0;
      tx_word_o   <= '0;
      clone_en_o  <= 1'b0;
      slot_wr_o   <= 1'b0;
      slot_addr_o <= '0;
      slot_freq_o <= '0;
      stat_rd_o   <= 1'b0;
      gen_rst_o   <= 1'b0;
    end else begin
      slot_wr_o <= 1'b0;
      stat_rd_o <= 1'b0;
      gen_rst_o <= 1'b0;
      if (commit_i) begin
        case (cmd_i)
          CMD_RST: begin
            sub_ctl_o  <= '0;
            aud_ctl_o  <= '0;
            tx_word_o  <= '0;
            clone_en_o <= 1'b0;
            gen_rst_o  <= 1'b1;
          end
          CMD_SUBCTL: sub_ctl_o  <= d0_i;
          CMD_AUDCTL: aud_ctl_o  <= d0_i;
          CMD_TXW:    tx_word_o  <= {d0_i, d1_i};
          CMD_CLONE:  clone_en_o <= d0_i[0];
          CMD_STAT:   stat_rd_o  <= 1'b1;
          CMD_SLOT: begin
            slot_wr_o   <= 1'b1;
            slot_addr_o <= slot_of(d0_i);
            slot_freq_o <= freq_of(d0_i, d1_i);
          end
          default: ;
        endcase
      end
    end
  end

  AST_WRITE_AT_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(sub_ctl_o) && $stable(aud_ctl_o) &&
                   $stable(tx_word_o) && $stable(clone_en_o))); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slot_wr_o, stat_rd_o, gen_rst_o})); // R4
  AST_SLOT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr_o |=> !slot_wr_o); // R4
  AST_RST_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rst_o |-> (sub_ctl_o == '0 && aud_ctl_o == '0 &&
                   tx_word_o == '0 && !clone_en_o)); // R6
  AST_STAT_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_o |=> !stat_rd_o); // R8
endmodule

// File: rtl/subtone_host_port.sv
module subtone_host_port
  import shp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic               csn_i,
  output logic               sdo_d_o,
  output logic               sdo_oe_o,
  input  logic [STAT_W-1:0]  stat_i,
  output logic [BYTE_W-1:0]  sub_ctl_o,
  output logic [BYTE_W-1:0]  aud_ctl_o,
  output logic [WORD_W-1:0]  tx_word_o,
  output logic               clone_en_o,
  output logic               slot_wr_o,
  output logic [SLOT_AW-1:0] slot_addr_o,
  output logic [FREQ_W-1:0]  slot_freq_o,
  output logic               stat_rd_o,
  output logic               gen_rst_o
);
  logic              sclk_rise, sdi_s, csn_s, cs_rise;
  logic              commit;
  logic [BYTE_W-1:0] cmd_b, d0_b, d1_b;

  shp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .csn_i      (csn_i),
    .sclk_rise_o(sclk_rise),
    .sdi_o      (sdi_s),
    .csn_o      (csn_s),
    .cs_rise_o  (cs_rise)
  );

  shp_deser #(.STAT_W(STAT_W)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise_i(sclk_rise),
    .sdi_i      (sdi_s),
    .csn_i      (csn_s),
    .cs_rise_i  (cs_rise),
    .stat_i     (stat_i),
    .commit_o   (commit),
    .cmd_o      (cmd_b),
    .d0_o       (d0_b),
    .d1_o       (d1_b),
    .sdo_d_o    (sdo_d_o),
    .sdo_oe_o   (sdo_oe_o)
  );

  shp_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit),
    .cmd_i      (cmd_b),
    .d0_i       (d0_b),
    .d1_i       (d1_b),
    .sub_ctl_o  (sub_ctl_o),
    .aud_ctl_o  (aud_ctl_o),
    .tx_word_o  (tx_word_o),
    .clone_en_o (clone_en_o),
    .slot_wr_o  (slot_wr_o),
    .slot_addr_o(slot_addr_o),
    .slot_freq_o(slot_freq_o),
    .stat_rd_o  (stat_rd_o),
    .gen_rst_o  (gen_rst_o)
  );

  AST_NO_COMMIT_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !csn_i |=> !(slot_wr_o && $past(csn_s) && !$past(commit))); // R10
  AST_STROBE_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr_o || stat_rd_o || gen_rst_o) |-> $past(commit)); // R10
endmodule

// File: tb/sim_subtone_host_port.sv
`timescale 1ns/1ps
module sim_subtone_host_port;
  localparam int HALF = 4;
  localparam int NV   = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic        sdo_d, sdo_oe;
  logic [3:0]  stat_in = 4'h0;
  logic [7:0]  sub_ctl, aud_ctl;
  logic [15:0] tx_word;
  logic        clone_en, slot_wr, stat_rd, gen_rst;
  logic [2:0]  slot_addr;
  logic [11:0] slot_freq;

  always #2 clk = ~clk;

  subtone_host_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .sdo_d_o(sdo_d), .sdo_oe_o(sdo_oe), .stat_i(stat_in),
    .sub_ctl_o(sub_ctl), .aud_ctl_o(aud_ctl), .tx_word_o(tx_word),
    .clone_en_o(clone_en), .slot_wr_o(slot_wr), .slot_addr_o(slot_addr),
    .slot_freq_o(slot_freq), .stat_rd_o(stat_rd), .gen_rst_o(gen_rst)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int slot_cnt = 0, rd_cnt = 0, gr_cnt = 0, oe_seen = 0;
  logic [2:0]  cap_addr;
  logic [11:0] cap_freq;

  always @(posedge clk) begin
    if (slot_wr) begin slot_cnt <= slot_cnt + 1; cap_addr <= slot_addr; cap_freq <= slot_freq; end
    if (stat_rd) rd_cnt <= rd_cnt + 1;
    if (gen_rst) gr_cnt <= gr_cnt + 1;
    if (sdo_oe)  oe_seen <= oe_seen + 1;
  end

  // stimulus table: command, byte 1, byte 2, data byte count
  localparam logic [25:0] VEC [NV] = '{
    {8'h80, 8'hA5, 8'h00, 2'd1},
    {8'h82, 8'h3C, 8'h00, 2'd1},
    {8'h83, 8'h0E, 8'h93, 2'd2},
    {8'h84, 8'h05, 8'hCF, 2'd2},
    {8'h84, 8'h63, 8'hC4, 2'd2},
    {8'h9C, 8'h01, 8'h00, 2'd1},
    {8'h80, 8'h41, 8'h00, 2'd1},
    {8'h83, 8'h1F, 8'hFF, 2'd2},
    {8'h9C, 8'h00, 8'h00, 2'd1},
    {8'h82, 8'hFF, 8'h00, 2'd1},
    {8'h84, 8'h7A, 8'hBC, 2'd2}
  };

  logic [7:0] m_sub = 0, m_aud = 0;
  logic [15:0] m_tx = 0;
  logic m_clone = 0;

  logic [7:0] rx_byte, oe_byte;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    rx_byte = 8'h00; oe_byte = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i];
      ticks(HALF);
      sclk = 1'b1;
      rx_byte[i] = sdo_d;
      oe_byte[i] = sdo_oe;
      ticks(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();   csn = 1'b0; ticks(HALF); endtask
  task automatic desel(); ticks(HALF); csn = 1'b1; ticks(12); endtask

  task automatic write_txn(input logic [7:0] c, input logic [7:0] a,
                           input logic [7:0] b, input int nb);
    sel();
    send_bits(c, 8);
    if (nb > 0) send_bits(a, 8);
    if (nb > 1) send_bits(b, 8);
    desel();
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " R1 R2 sub ctl"}, 32'(sub_ctl), 32'(m_sub));
    chk({tag, " R2 aud ctl"},    32'(aud_ctl), 32'(m_aud));
    chk({tag, " R3 tx word"},    32'(tx_word), 32'(m_tx));
    chk({tag, " R5 clone"},      32'(clone_en), 32'(m_clone));
  endtask

  initial begin
    int s0, r0, g0, o0;
    ticks(5);
    // R13: reset state
    chk("R13 reset sub",   32'(sub_ctl), 0);
    chk("R13 reset tx",    32'(tx_word), 0);
    chk("R13 reset oe",    32'(sdo_oe), 0);
    chk("R13 reset strobes", 32'({slot_wr, stat_rd, gen_rst}), 0);
    rst_n = 1'b1;
    ticks(4);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] c, a, b;
      int nb;
      c = VEC[v][25:18]; a = VEC[v][17:10]; b = VEC[v][9:2]; nb = int'(VEC[v][1:0]);
      s0 = slot_cnt;
      write_txn(c, a, b, nb);
      case (c)
        8'h80: m_sub = a;
        8'h82: m_aud = a;
        8'h83: m_tx = {a, b};
        8'h9C: m_clone = a[0];
        default: ;
      endcase
      check_regs("vec");
      if (c == 8'h84) begin
        chk("R4 slot strobe count", 32'(slot_cnt - s0), 1);
        chk("R4 slot addr", 32'(cap_addr), 32'(a[6:4]));
        chk("R4 slot freq", 32'(cap_freq), 32'({a[3:0], b}));
      end else begin
        chk("R4 no slot strobe", 32'(slot_cnt - s0), 0);
      end
    end

    // R7 R8 R9: full status read
    stat_in = 4'hB;
    r0 = rd_cnt;
    sel();
    send_bits(8'h81, 8);
    chk("R9 oe low during command", 32'(oe_byte), 0);
    send_bits(8'h00, 8);
    chk("R7 reply byte", 32'(rx_byte), 32'h0B);
    chk("R9 oe high during reply", 32'(oe_byte), 32'hFF);
    desel();
    chk("R9 oe low after deselect", 32'(sdo_oe), 0);
    chk("R8 status strobe once", 32'(rd_cnt - r0), 1);

    // R8: aborted status read
    stat_in = 4'h5;
    r0 = rd_cnt;
    sel();
    send_bits(8'h81, 8);
    send_bits(8'h00, 4);
    chk("R7 partial reply bits", 32'(rx_byte[7:4]), 32'h0);
    desel();
    chk("R8 aborted read no strobe", 32'(rd_cnt - r0), 0);
    chk("R9 oe low after abort", 32'(sdo_oe), 0);

    // R10: abort after command byte, and mid data byte
    sel(); send_bits(8'h80, 8); desel();
    chk("R10 cmd-only abort keeps sub", 32'(sub_ctl), 32'(m_sub));
    s0 = slot_cnt;
    sel(); send_bits(8'h84, 8); send_bits(8'h12, 8); send_bits(8'h34, 5); desel();
    chk("R10 mid-byte abort no slot strobe", 32'(slot_cnt - s0), 0);
    sel(); send_bits(8'h82, 8); send_bits(8'h00, 5); desel();
    chk("R10 mid-byte abort keeps aud", 32'(aud_ctl), 32'(m_aud));

    // R11: unknown command with data
    s0 = slot_cnt; r0 = rd_cnt; g0 = gr_cnt; o0 = oe_seen;
    write_txn(8'h55, 8'h81, 8'h84, 2);
    check_regs("R11 unknown");
    chk("R11 unknown no strobes", 32'((slot_cnt - s0) + (rd_cnt - r0) + (gr_cnt - g0)), 0);
    chk("R11 unknown no reply drive", 32'(oe_seen - o0), 0);

    // R12: surplus bytes
    sel(); send_bits(8'h80, 8); send_bits(8'h12, 8); send_bits(8'h34, 8); send_bits(8'h56, 8); desel();
    m_sub = 8'h12;
    chk("R12 surplus bytes ignored", 32'(sub_ctl), 32'h12);

    // R6: general reset command
    g0 = gr_cnt;
    write_txn(8'h01, 8'h00, 8'h00, 0);
    m_sub = 0; m_aud = 0; m_tx = 0; m_clone = 0;
    check_regs("R6 general reset");
    chk("R6 reset strobe once", 32'(gr_cnt - g0), 1);
    stat_in = 4'hE;
    sel(); send_bits(8'h81, 8); send_bits(8'h00, 8); desel();
    chk("R6 status bits kept", 32'(rx_byte), 32'h0E);

    // R13: hardware reset after activity
    write_txn(8'h83, 8'hAB, 8'hCD, 2);
    write_txn(8'h9C, 8'h01, 8'h00, 1);
    @(negedge clk) rst_n = 1'b0;
    ticks(2);
    chk("R13 hw reset tx", 32'(tx_word), 0);
    chk("R13 hw reset clone", 32'(clone_en), 0);
    rst_n = 1'b1;
    ticks(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule